// File: doc/BRIEF.md
# Masked Address Window Translator

This block sits on the outbound path from a local bus to a PCI address space. It holds three programmable windows. Each window has three byte-wide fields: a base, a don't-care mask and a translation value. All three act only on the top byte of a 32-bit address. For each request the block reports whether an enabled window matched, which window it was, and the 32-bit address to present on the PCI side.

The mask has two roles. A set mask bit removes that top-byte bit from the match compare, and the same bit lets the incoming address bit pass to the output unchanged. A clear mask bit takes part in the compare, and its output bit is replaced by the translation value. Translation cannot be turned off. To get an identity mapping, software writes equal base and translation values.

Configuration uses a simple write strobe with a combinational read path. There is one 32-bit register per window and one register of window enables. Requests use a valid/ready handshake, and each result is registered.

Top module: `addrWinXlate`

## Requirements
- R1: After reset every window field and every enable bit is 0, rspValid is 0 and reqReady is 1. A request made with no window enabled reports a miss.
- R2: Window i sits at config offset 0xB70 + 4*i (0xB70, 0xB74, 0xB78) with the base in bits 31:24, the mask in bits 23:16, the translation in bits 15:8, and bits 7:0 reading 0. The enable register at 0xB7C holds window i's enable in bit i, and its upper bits read 0.
- R3: An enabled window hits when every top-address bit 24+i whose mask bit 16+i is 0 equals base bit 24+i.
- R4: A mask bit of 1 excludes its address bit from the compare. A window whose mask is all ones hits on any address.
- R5: On a hit, output bit 24+i equals translation bit 8+i when mask bit 16+i is 0, and equals the incoming bit when the mask bit is 1. When base equals translation the address is unchanged.
- R6: Output bits 23:0 always equal the request's bits 23:0.
- R7: A disabled window never hits. On a miss rspHit is 0, rspWin is 0 and rspAddr equals the request address.
- R8: When several enabled windows hit, the lowest-numbered one is reported in rspWin and supplies the translation.
- R9: A request is accepted on a clock edge where reqValid and reqReady are both 1. rspValid is 1 for exactly the cycle after each accepted request and 0 otherwise, so back-to-back requests give back-to-back results.
- R10: reqReady is 0 in any cycle where cfgWrEn is 1, so no request is accepted while settings change.
- R11: Writes to offsets outside the four registers change nothing, and reads there return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Config write strobe |
| cfgAddr | input | 12 | Config register offset |
| cfgWrData | input | 32 | Config write data |
| cfgRdData | output | 32 | Config read data for cfgAddr (combinational) |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request can be accepted |
| reqAddr | input | 32 | Local bus request address |
| rspValid | output | 1 | Result valid |
| rspHit | output | 1 | Some enabled window matched |
| rspWin | output | 2 | Index of the matching window |
| rspAddr | output | 32 | Translated outbound address |

## Verification
The bench targets the mask's double role with a window that is half masked. A design that used the mask only for the compare, or inverted its sense, would produce a wrong mixed top byte. All three windows are made to match one address, so a design that chose the highest index or combined translations would report the wrong window. Disabled but matching windows, out-of-map writes and requests made during a config write cover designs that leak disabled windows, alias the register map or accept mid-update. A randomized sweep is checked against a model built from the requirements.

// File: rtl/addrWinPkg.sv
package addrWinPkg;
  localparam int NUM_WIN   = 3;
  localparam int IDX_W     = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int ADDR_W    = 32;
  localparam int TOP_W     = 8;
  localparam int LOW_W     = ADDR_W - TOP_W;
  localparam int CFG_A_W   = 12;
  localparam int CFG_D_W   = 32;
  localparam logic [CFG_A_W-1:0] WIN_OFS0 = 12'hB70;
  localparam logic [CFG_A_W-1:0] EN_OFS   = WIN_OFS0 + CFG_A_W'(4 * NUM_WIN);

  typedef struct packed {
    logic               accept;
    logic [NUM_WIN-1:0] wrWin;
    logic               wrEn;
    logic [NUM_WIN-1:0] rdWin;
    logic               rdEn;
  } ctrlStrobe_t;
endpackage

// File: rtl/addrWinCtrl.sv
module addrWinCtrl
  import addrWinPkg::*;
(
  input  logic               cfgWrEn,
  input  logic [CFG_A_W-1:0] cfgAddr,
  input  logic               reqValid,
  output logic               reqReady,
  output ctrlStrobe_t        strobe
);
  logic [NUM_WIN-1:0] winSel;
  logic               enSel;

  for (genvar g = 0; g < NUM_WIN; g++) begin : gDec
    assign winSel[g] = (cfgAddr == WIN_OFS0 + CFG_A_W'(4 * g));
  end
  assign enSel = (cfgAddr == EN_OFS);

  // stall requests while settings are being written
  assign reqReady = ~cfgWrEn;

  always_comb begin
    strobe        = '0;
    strobe.accept = reqValid & reqReady;
    strobe.wrWin  = cfgWrEn ? winSel : '0;
    strobe.wrEn   = cfgWrEn & enSel;
    strobe.rdWin  = winSel;
    strobe.rdEn   = enSel;
  end
endmodule

// File: rtl/addrWinData.sv
module addrWinData
  import addrWinPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [CFG_D_W-1:0] cfgWrData,
  output logic [CFG_D_W-1:0] cfgRdData,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               rspValid,
  output logic               rspHit,
  output logic [IDX_W-1:0]   rspWin,
  output logic [ADDR_W-1:0]  rspAddr
);
  logic [TOP_W-1:0]   winBase [NUM_WIN];
  logic [TOP_W-1:0]   winMask [NUM_WIN];
  logic [TOP_W-1:0]   winXlat [NUM_WIN];
  logic [NUM_WIN-1:0] winEn;
  logic [NUM_WIN-1:0] match;
  logic [TOP_W-1:0]   xTop [NUM_WIN];
  logic [TOP_W-1:0]   reqTop;
  logic               anyHit;
  logic [IDX_W-1:0]   selIdx;
  logic [TOP_W-1:0]   selTop;

  assign reqTop = reqAddr[ADDR_W-1:LOW_W];

  for (genvar g = 0; g < NUM_WIN; g++) begin : gWin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        winBase[g] <= '0;
        winMask[g] <= '0;
        winXlat[g] <= '0;
      end else if (strobe.wrWin[g]) begin
        winBase[g] <= cfgWrData[31:24];
        winMask[g] <= cfgWrData[23:16];
        winXlat[g] <= cfgWrData[15:8];
      end
    end
    assign match[g] = winEn[g] & (((reqTop ^ winBase[g]) & ~winMask[g]) == '0);
    assign xTop[g]  = (winXlat[g] & ~winMask[g]) | (reqTop & winMask[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            winEn <= '0;
    else if (strobe.wrEn) winEn <= cfgWrData[NUM_WIN-1:0];
  end

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    anyHit = 1'b0;
    selIdx = '0;
    selTop = reqTop;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        anyHit = 1'b1;
        selIdx = IDX_W'(i);
        selTop = xTop[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspWin   <= '0;
      rspAddr  <= '0;
    end else begin
      rspValid <= strobe.accept;
      if (strobe.accept) begin
        rspHit  <= anyHit;
        rspWin  <= selIdx;
        rspAddr <= {selTop, reqAddr[LOW_W-1:0]};
      end
    end
  end

  always_comb begin
    cfgRdData = '0;
    for (int i = 0; i < NUM_WIN; i++)
      if (strobe.rdWin[i]) cfgRdData = {winBase[i], winMask[i], winXlat[i], 8'h00};
    if (strobe.rdEn) cfgRdData = {{(CFG_D_W - NUM_WIN){1'b0}}, winEn};
  end
endmodule

// File: rtl/addrWinXlate.sv
module addrWinXlate
  import addrWinPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [CFG_A_W-1:0] cfgAddr,
  input  logic [CFG_D_W-1:0] cfgWrData,
  output logic [CFG_D_W-1:0] cfgRdData,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               rspValid,
  output logic               rspHit,
  output logic [IDX_W-1:0]   rspWin,
  output logic [ADDR_W-1:0]  rspAddr
);
  ctrlStrobe_t strobe;

  addrWinCtrl i_ctrl (
    .cfgWrEn (cfgWrEn),
    .cfgAddr (cfgAddr),
    .reqValid(reqValid),
    .reqReady(reqReady),
    .strobe  (strobe)
  );

  addrWinData i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData),
    .reqAddr  (reqAddr),
    .rspValid (rspValid),
    .rspHit   (rspHit),
    .rspWin   (rspWin),
    .rspAddr  (rspAddr)
  );
endmodule

// File: rtl/addrWinChecker.sv
module addrWinChecker
  import addrWinPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              rspHit,
  input logic [IDX_W-1:0]  rspWin,
  input logic [ADDR_W-1:0] rspAddr
);
  assert_rsp_after_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> rspValid);

  assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqReady) |=> !rspValid);

  assert_stall_on_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |-> !reqReady);

  assert_low_bits_pass_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (rspAddr[LOW_W-1:0] == $past(reqAddr[LOW_W-1:0])));

  assert_miss_clean_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (rspHit || (rspWin == '0 && rspAddr == $past(reqAddr))));

  assert_win_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspHit) |-> (int'(rspWin) < NUM_WIN));
endmodule

bind addrWinXlate addrWinChecker i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgWrEn (cfgWrEn),
  .reqValid(reqValid),
  .reqReady(reqReady),
  .reqAddr (reqAddr),
  .rspValid(rspValid),
  .rspHit  (rspHit),
  .rspWin  (rspWin),
  .rspAddr (rspAddr)
);

// File: tb/test_addrWinXlate.sv
module test_addrWinXlate;
  logic        clk = 0;
  logic        rstN = 0;
  logic        cfgWrEn = 0;
  logic [11:0] cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        reqValid = 0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic        rspValid;
  logic        rspHit;
  logic [1:0]  rspWin;
  logic [31:0] rspAddr;

  int checks = 0;
  int errors = 0;

  // shadow settings kept from the requirements
  logic [7:0] sBase [3];
  logic [7:0] sMask [3];
  logic [7:0] sXlat [3];
  logic [2:0] sEn;

  always #5 clk = ~clk;

  addrWinXlate i_addrWinXlate (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .rspValid(rspValid),
    .rspHit(rspHit), .rspWin(rspWin), .rspAddr(rspAddr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 0;
    for (int i = 0; i < 3; i++)
      if (a == 12'hB70 + 12'(4 * i)) begin
        sBase[i] = d[31:24]; sMask[i] = d[23:16]; sXlat[i] = d[15:8];
      end
    if (a == 12'hB7C) sEn = d[2:0];
  endtask

  task automatic rdReg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdData;
  endtask

  function automatic void model(input logic [31:0] a, output logic hit,
                                output logic [1:0] idx, output logic [31:0] o);
    hit = 0; idx = 0; o = a;
    for (int i = 0; i < 3; i++) begin
      if (!hit && sEn[i] && (((a[31:24] ^ sBase[i]) & ~sMask[i]) == 8'h00)) begin
        hit = 1; idx = 2'(i);
        o[31:24] = (sXlat[i] & ~sMask[i]) | (a[31:24] & sMask[i]);
      end
    end
  endfunction

  // one request; result sampled at the following negedge
  task automatic sendReq(input logic [31:0] a, input string req);
    logic eh; logic [1:0] ei; logic [31:0] eo;
    model(a, eh, ei, eo);
    @(negedge clk);
    reqValid = 1; reqAddr = a;
    @(negedge clk);
    reqValid = 0;
    check(rspValid === 1'b1, {req, " valid"}, 32'(rspValid), 32'h1);
    check(rspHit === eh, {req, " hit"}, 32'(rspHit), 32'(eh));
    check(rspWin === ei, {req, " win"}, 32'(rspWin), 32'(ei));
    check(rspAddr === eo, {req, " addr"}, rspAddr, eo);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(rspValid === 1'b0, "R1 rspValid", 32'(rspValid), 0);
    check(reqReady === 1'b1, "R1 reqReady", 32'(reqReady), 1);
    for (int i = 0; i < 4; i++) begin
      rdReg(12'hB70 + 12'(4 * i), d);
      check(d === 32'h0, "R1 reg reset", d, 0);
    end
    sendReq(32'h12345678, "R1 miss after reset");
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wrReg(12'hB70, 32'h11223344);
    wrReg(12'hB74, 32'h556677FF);
    wrReg(12'hB78, 32'h99AABBCC);
    wrReg(12'hB7C, 32'hFFFFFFF8);
    rdReg(12'hB70, d); check(d === 32'h11223300, "R2 win0", d, 32'h11223300);
    rdReg(12'hB74, d); check(d === 32'h55667700, "R2 win1", d, 32'h55667700);
    rdReg(12'hB78, d); check(d === 32'h99AABB00, "R2 win2", d, 32'h99AABB00);
    rdReg(12'hB7C, d); check(d === 32'h0, "R2 enable low bits", d, 0);
    // R11: out-of-map writes must not alias
    wrReg(12'hB80, 32'hFFFFFFFF);
    wrReg(12'hB6C, 32'hFFFFFFFF);
    wrReg(12'h370, 32'hFFFFFFFF);
    rdReg(12'hB80, d); check(d === 32'h0, "R11 unmapped read", d, 0);
    rdReg(12'hB70, d); check(d === 32'h11223300, "R11 win0 untouched", d, 32'h11223300);
    rdReg(12'hB7C, d); check(d === 32'h0, "R11 enable untouched", d, 0);
    wrReg(12'hB7C, 32'h5);
    rdReg(12'hB7C, d); check(d === 32'h5, "R2 enable bits", d, 5);
    wrReg(12'hB7C, 32'h0);
  endtask

  task automatic t_exact();
    wrReg(12'hB70, 32'h40008000);
    wrReg(12'hB7C, 32'h1);
    sendReq(32'h40123456, "R3 exact hit");
    check(rspAddr === 32'h80123456, "R3 translated", rspAddr, 32'h80123456);
    sendReq(32'h41123456, "R3 one bit off miss");
    check(rspHit === 1'b0, "R7 miss flag", 32'(rspHit), 0);
  endtask

  task automatic t_mask();
    wrReg(12'hB74, 32'h200FA500);
    wrReg(12'hB7C, 32'h2);
    sendReq(32'h2BABCDEF, "R4 masked nibble hit");
    check(rspAddr === 32'hABABCDEF, "R5 mixed top byte", rspAddr, 32'hABABCDEF);
    sendReq(32'h3BABCDEF, "R4 unmasked bit miss");
    wrReg(12'hB74, 32'h00FF0000);
    sendReq(32'hDE00BEEF, "R4 all-masked hit");
    check(rspAddr === 32'hDE00BEEF, "R6 passthrough", rspAddr, 32'hDE00BEEF);
    wrReg(12'hB74, 32'h7C007C00);
    sendReq(32'h7C0A0B0C, "R5 identity");
    check(rspAddr === 32'h7C0A0B0C, "R5 identity addr", rspAddr, 32'h7C0A0B0C);
  endtask

  task automatic t_disabled();
    wrReg(12'hB78, 32'h55006600);
    wrReg(12'hB7C, 32'h0);
    sendReq(32'h55FFFFFF, "R7 disabled win2");
    check(rspHit === 1'b0 && rspAddr === 32'h55FFFFFF, "R7 disabled miss", rspAddr, 32'h55FFFFFF);
  endtask

  task automatic t_priority();
    wrReg(12'hB70, 32'h00FF1100);
    wrReg(12'hB74, 32'h00FF2200);
    wrReg(12'hB78, 32'h00FF3300);
    wrReg(12'hB7C, 32'h7);
    sendReq(32'h01020304, "R8 all hit");
    check(rspWin === 2'd0, "R8 lowest wins", 32'(rspWin), 0);
    wrReg(12'hB7C, 32'h6);
    sendReq(32'h01020304, "R8 win1 wins");
    check(rspWin === 2'd1, "R8 next lowest", 32'(rspWin), 1);
  endtask

  task automatic t_timing();
    @(negedge clk);
    check(rspValid === 1'b0, "R9 idle", 32'(rspValid), 0);
    reqValid = 1; reqAddr = 32'hAAAA0001;
    @(negedge clk);
    check(rspValid === 1'b1, "R9 first", 32'(rspValid), 1);
    reqAddr = 32'hBBBB0002;
    @(negedge clk);
    reqValid = 0;
    check(rspValid === 1'b1 && rspAddr[23:0] === 24'hBB0002, "R9 back-to-back", rspAddr, 32'hBBBB0002);
    @(negedge clk);
    check(rspValid === 1'b0, "R9 drops", 32'(rspValid), 0);
  endtask

  task automatic t_wrStall();
    @(negedge clk);
    cfgWrEn = 1; cfgAddr = 12'hB80; cfgWrData = 32'h0;
    reqValid = 1; reqAddr = 32'h12121212;
    #1 check(reqReady === 1'b0, "R10 ready low", 32'(reqReady), 0);
    @(negedge clk);
    check(rspValid === 1'b0, "R10 not accepted", 32'(rspValid), 0);
    cfgWrEn = 0;
    @(negedge clk);
    reqValid = 0;
    check(rspValid === 1'b1, "R10 accepted after write", 32'(rspValid), 1);
  endtask

  task automatic t_random();
    for (int n = 0; n < 150; n++) begin
      for (int i = 0; i < 3; i++)
        wrReg(12'hB70 + 12'(4 * i), {$urandom() % 4 == 0 ? 8'h00 : 8'($urandom()),
                                      8'($urandom() & $urandom()), 8'($urandom()), 8'h00});
      wrReg(12'hB7C, 32'($urandom() % 8));
      for (int k = 0; k < 4; k++) begin
        logic [31:0] a;
        a = $urandom();
        if (k < 2) a[31:24] = sBase[k] ^ (8'($urandom()) & sMask[k]);
        sendReq(a, "R3 R5 R8 random");
      end
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin sBase[i] = 0; sMask[i] = 0; sXlat[i] = 0; end
    sEn = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_regmap();
    t_exact();
    t_mask();
    t_disabled();
    t_priority();
    t_timing();
    t_wrStall();
    t_random();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule